// File: doc/BRIEF.md
# Two-Bank Interrupt Controller with Latched Edges

This controller gathers 64 interrupt sources into two 32-bit banks and presents them to a processor on two request lines. One line is the normal interrupt request and the other is the fast interrupt request. Source n sits in bank n>>5 at bit n&31. Every per-source register exists as a pair of words. The low-bank word is at a base offset and the high-bank word is 4 bytes above it, so the two banks are interleaved across the map.

Each source is either level-sensitive or edge-sensitive. A level source reflects its synchronized input directly. An edge source is caught in a latch, which software clears explicitly once it has served the source. A software trigger can force any source pending. Enables and triggers each have separate set and clear words, so that one source can be changed without a read-modify-write.

Software reads the two normal-request status words, low bank first, and services the lowest set bit. A zero status word means that bank has nothing to serve.

Top module: `dbank_intc`

## Requirements
- R1: Base offsets, low bank at base and high bank at base+4, with source n at bit n&31 of bank n>>5:
  - 0x00 normal-request status
  - 0x08 fast-request status
  - 0x10 raw status
  - 0x18 route
  - 0x20 enable-set
  - 0x28 enable-clear
  - 0x30 trigger-set
  - 0x38 trigger-clear
  - 0x40 sense
  - 0x48 both-edge
  - 0x50 polarity
  - 0x58 latch-clear
  - 0x60 latch status

  Reads of the clear words, and of any address at or above 0x80, return zero.
- R2: Writing the enable-set word sets only the enable bits written as one. Writing the enable-clear word clears only the enable bits written as one. Reading 0x20/0x24 returns the enables.
- R3: The trigger-set and trigger-clear words work the same way on the software-trigger bits. A set trigger bit makes the source's raw status bit one, and writing all ones to trigger-clear removes every trigger in that bank.
- R4: A route bit of 0 sends the source to the normal request. A route bit of 1 sends it to the fast request.
- R5: A sense bit of 1 means level-sensitive and 0 means edge-sensitive. Bits selected by parameter FIXED_MASK always read FIXED_LEVEL and ignore writes. The other bits are read/write.
- R6: For a level source, the raw status bit is the input after a two-flop synchronizer. An input change shows in raw status two clocks later.
- R7: For an edge source with both-edge 0, polarity 1 latches rising edges and polarity 0 latches falling edges. With both-edge 1 the source latches on either edge and ignores polarity. The raw bit is the latch, which reads back at 0x60/0x64.
- R8: Writing a one to a latch-clear bit clears that edge latch. If an edge is detected in the same cycle as the clear, the latch stays set. Latch-clear has no effect on a level source's raw status.
- R9: Normal-request status = raw & enable & ~route. Fast-request status = raw & enable & route. A bank's status word reads zero when none of its enabled sources on that line is pending.
- R10: irq_o and fiq_o are registered. Each equals, one clock later, the OR of its 64-bit status.
- R11: Reset clears enables, triggers, routes, latches, both-edge bits and both outputs. It sets polarity to rising and sense to SENSE_RST, with the fixed bits forced to FIXED_LEVEL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | 64 | Interrupt source inputs, asynchronous |
| bus_we | input | 1 | Write strobe for the current bus address |
| bus_addr | input | AW | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with FIXED_MASK covering bits 0-3 and 32-39. FIXED_LEVEL makes bits 0 and 2 level and bits 1 and 3 edge, and in the high bank bits 32-35 level and 36-39 edge. This brings within reach:
- writes to sense words that must leave a mix of fixed level and fixed edge bits untouched;
- a latch-clear on a permanently level source.

SENSE_RST starts the programmable bits in a checkerboard, so both kinds of source are live from the first random cycle. A directed case lands a latch-clear on the exact cycle an edge is detected.

// File: rtl/dbank_intc.sv
module dbank_intc #(
  parameter int          AW          = 8,
  parameter logic [63:0] FIXED_MASK  = 64'h0,
  parameter logic [63:0] FIXED_LEVEL = 64'h0,
  parameter logic [63:0] SENSE_RST   = 64'hFFFF_FFFF_FFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   src,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam logic [63:0] SENSE_INIT = (SENSE_RST & ~FIXED_MASK) | (FIXED_LEVEL & FIXED_MASK);
  localparam logic [3:0] W_ISTAT = 4'd0, W_FSTAT = 4'd1, W_RAW = 4'd2, W_ROUTE = 4'd3,
                         W_ENSET = 4'd4, W_ENCLR = 4'd5, W_TRSET = 4'd6, W_TRCLR = 4'd7,
                         W_SENSE = 4'd8, W_BOTH = 4'd9, W_POL = 4'd10, W_LCLR = 4'd11,
                         W_LSTAT = 4'd12;

  logic [63:0] en, trig, route, sense, both, pol, lat;
  logic [63:0] s1, s2, s3;
  logic [63:0] rise, fall, det, raw, ist, fst, rd64;

  wire         in_rng = (bus_addr >> 7) == '0;
  wire  [3:0]  widx   = bus_addr[6:3];
  wire  [63:0] wmask  = bus_addr[2] ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};
  wire  [63:0] keep   = bus_addr[2] ? {32'h0, 32'hFFFF_FFFF} : {32'hFFFF_FFFF, 32'h0};

  function automatic logic hit(input logic we, input logic rng, input logic [3:0] i, input logic [3:0] k);
    return we && rng && (i == k);
  endfunction

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
  assign det  = ~sense & ((both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall))));
  assign raw  = (sense & s2) | (~sense & lat) | trig;
  assign ist  = raw & en & ~route;
  assign fst  = raw & en & route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= src; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      trig  <= '0;
      route <= '0;
      sense <= SENSE_INIT;
      both  <= '0;
      pol   <= '1;
      lat   <= '0;
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      if (hit(bus_we, in_rng, widx, W_ENSET)) en <= en | wmask;
      else if (hit(bus_we, in_rng, widx, W_ENCLR)) en <= en & ~wmask;
      if (hit(bus_we, in_rng, widx, W_TRSET)) trig <= trig | wmask;
      else if (hit(bus_we, in_rng, widx, W_TRCLR)) trig <= trig & ~wmask;
      if (hit(bus_we, in_rng, widx, W_ROUTE)) route <= (route & keep) | wmask;
      if (hit(bus_we, in_rng, widx, W_SENSE))
        sense <= (((sense & keep) | wmask) & ~FIXED_MASK) | (FIXED_LEVEL & FIXED_MASK);
      if (hit(bus_we, in_rng, widx, W_BOTH)) both <= (both & keep) | wmask;
      if (hit(bus_we, in_rng, widx, W_POL))  pol  <= (pol & keep) | wmask;
      if (hit(bus_we, in_rng, widx, W_LCLR)) lat <= (lat & ~(wmask & ~sense)) | det;
      else lat <= lat | det;
      irq_o <= |ist;
      fiq_o <= |fst;
    end
  end

  always_comb begin
    case (widx)
      W_ISTAT: rd64 = ist;
      W_FSTAT: rd64 = fst;
      W_RAW:   rd64 = raw;
      W_ROUTE: rd64 = route;
      W_ENSET: rd64 = en;
      W_TRSET: rd64 = trig;
      W_SENSE: rd64 = sense;
      W_BOTH:  rd64 = both;
      W_POL:   rd64 = pol;
      W_LSTAT: rd64 = lat;
      default: rd64 = '0;
    endcase
  end

  assign bus_rdata = !in_rng ? 32'h0 : (bus_addr[2] ? rd64[63:32] : rd64[31:0]);
endmodule

// File: rtl/dbank_intc_chk.sv
module dbank_intc_chk #(
  parameter int          AW          = 8,
  parameter logic [63:0] FIXED_MASK  = 64'h0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          irq_o,
  input logic          fiq_o,
  input logic [63:0]   en,
  input logic [63:0]   route,
  input logic [63:0]   sense
);
  AST_EN_SET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(8'h20)) |=> ((en[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R2
  AST_EN_CLR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(8'h2C)) |=> ((en[63:32] & $past(bus_wdata)) == 32'h0)); // R2
  AST_FIXED_SENSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[AW-1:3] == (AW-3)'(8)) |=> ((sense & FIXED_MASK) == ($past(sense) & FIXED_MASK))); // R5
  AST_FIQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(|(en & route))); // R4
  AST_IRQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(en & ~route))); // R10
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && !fiq_o && en == 64'h0 && route == 64'h0)); // R11
endmodule

bind dbank_intc dbank_intc_chk #(.AW(AW), .FIXED_MASK(FIXED_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_o(irq_o), .fiq_o(fiq_o), .en(en), .route(route), .sense(sense)
);

// File: tb/dbank_intc_bench.sv
module dbank_intc_bench;
  localparam logic [63:0] FM = 64'h0000_00FF_0000_000F;
  localparam logic [63:0] FL = 64'h0000_000F_0000_0005;
  localparam logic [63:0] SR = 64'h5555_AAAA_5555_AAAA;

  logic clk = 0, rst_n = 0, bus_we = 0, irq_o, fiq_o;
  logic [63:0] src = '0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  dbank_intc #(.AW(8), .FIXED_MASK(FM), .FIXED_LEVEL(FL), .SENSE_RST(SR)) u_dbank_intc (
    .clk(clk), .rst_n(rst_n), .src(src), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  logic [63:0] m_en, m_tr, m_rt, m_se, m_bo, m_po, m_la, m_s1, m_s2, m_s3;
  logic m_irq, m_fiq;

  function automatic logic [63:0] m_raw();
    return (m_se & m_s2) | (~m_se & m_la) | m_tr;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= '0; m_tr <= '0; m_rt <= '0; m_se <= (SR & ~FM) | (FL & FM);
      m_bo <= '0; m_po <= '1; m_la <= '0; m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
      m_irq <= 0; m_fiq <= 0;
    end else begin
      logic [63:0] wm, kp, ed, r;
      wm = bus_addr[2] ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};
      kp = bus_addr[2] ? 64'h0000_0000_FFFF_FFFF : 64'hFFFF_FFFF_0000_0000;
      ed = ~m_se & ((m_bo & (m_s2 ^ m_s3)) |
                    (~m_bo & m_po & m_s2 & ~m_s3) | (~m_bo & ~m_po & ~m_s2 & m_s3));
      r = m_raw();
      m_s1 <= src; m_s2 <= m_s1; m_s3 <= m_s2;
      m_irq <= |(r & m_en & ~m_rt);
      m_fiq <= |(r & m_en & m_rt);
      m_la <= m_la | ed;
      if (bus_we && !bus_addr[7]) begin
        case (bus_addr[6:3])
          4'd3:  m_rt <= (m_rt & kp) | wm;
          4'd4:  m_en <= m_en | wm;
          4'd5:  m_en <= m_en & ~wm;
          4'd6:  m_tr <= m_tr | wm;
          4'd7:  m_tr <= m_tr & ~wm;
          4'd8:  m_se <= (((m_se & kp) | wm) & ~FM) | (FL & FM);
          4'd9:  m_bo <= (m_bo & kp) | wm;
          4'd10: m_po <= (m_po & kp) | wm;
          4'd11: m_la <= (m_la & ~(wm & ~m_se)) | ed;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [63:0] w;
    case (a[6:3])
      4'd0: w = m_raw() & m_en & ~m_rt;
      4'd1: w = m_raw() & m_en & m_rt;
      4'd2: w = m_raw();
      4'd3: w = m_rt;
      4'd4: w = m_en;
      4'd6: w = m_tr;
      4'd8: w = m_se;
      4'd9: w = m_bo;
      4'd10: w = m_po;
      4'd12: w = m_la;
      default: w = '0;
    endcase
    if (a[7]) return 32'h0;
    return a[2] ? w[63:32] : w[31:0];
  endfunction

  function automatic string rtag(input logic [7:0] a);
    if (a[7]) return "R1";
    case (a[6:3])
      4'd0, 4'd1: return "R9";
      4'd2: return "R6";
      4'd3: return "R4";
      4'd4, 4'd5: return "R2";
      4'd6, 4'd7: return "R3";
      4'd8: return "R5";
      4'd9, 4'd10, 4'd12: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [31:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3); rst_n = 1; idle(2);
    // R11 reset state
    check("R11", {30'h0, irq_o, fiq_o}, 32'h0);
    rd(8'h20, "R11", 32'h0); rd(8'h1C, "R11", 32'h0);
    rd(8'h64, "R11", 32'h0); rd(8'h50, "R11", 32'hFFFF_FFFF);
    rd(8'h40, "R11", 32'h5555_AAA5);
    // R5 fixed sense bits ignore writes
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, "R5", 32'hFFFF_FFF5);
    wr(8'h44, 32'h0);         rd(8'h44, "R5", 32'h0000_000F);
    // R2 set/clear only touch ones
    wr(8'h24, 32'h0000_0300); wr(8'h24, 32'h0000_0001);
    wr(8'h2C, 32'h0000_0100); rd(8'h24, "R2", 32'h0000_0201);
    // R8 edge detected in the clear cycle keeps the latch
    wr(8'h4C, 32'h0); wr(8'h54, 32'hFFFF_FDFF);
    @(negedge clk); src[40] = 1;
    @(negedge clk);
    wr(8'h5C, 32'h0000_0100);
    rd(8'h64, "R8", 32'h0000_0100);
    wr(8'h5C, 32'h0000_0100); rd(8'h64, "R8", 32'h0);
    // R7 falling edge on bit 41 routed to fast request (R4)
    wr(8'h1C, 32'h0000_0200);
    src[41] = 1; idle(4);
    check("R7", {31'h0, fiq_o}, 32'h0);
    src[41] = 0; idle(4);
    check("R4", {31'h0, fiq_o}, 32'h1);
    check("R10", {31'h0, irq_o}, 32'h0);
    rd(8'h0C, "R9", 32'h0000_0200);
    wr(8'h5C, 32'h0000_0200); idle(2);
    check("R10", {31'h0, fiq_o}, 32'h0);
    // R6 level source, R8 clear has no effect on it, R10 output
    wr(8'h20, 32'h0000_0001);
    src[0] = 1; @(negedge clk); rd(8'h10, "R6", 32'h0);
    @(negedge clk); rd(8'h10, "R6", 32'h1);
    wr(8'h58, 32'hFFFF_FFFF); rd(8'h10, "R8", 32'h1);
    check("R10", {31'h0, irq_o}, 32'h1);
    rd(8'h00, "R9", 32'h1); rd(8'h04, "R9", 32'h0);
    // R3 soft trigger set and full clear
    src[0] = 0; wr(8'h20, 32'h0000_0010); wr(8'h30, 32'h0000_0010);
    rd(8'h10, "R3", 32'h0000_0010);
    @(negedge clk); check("R3", {31'h0, irq_o}, 32'h1);
    wr(8'h38, 32'hFFFF_FFFF); rd(8'h34, "R3", 32'h0); rd(8'h30, "R3", 32'h0);
    idle(3); check("R10", {31'h0, irq_o}, 32'h0);
    // R1 out of range and clear-word reads
    rd(8'h80, "R1", 32'h0); rd(8'h28, "R1", 32'h0);

    // random phase
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      check("R10", {30'h0, irq_o, fiq_o}, {30'h0, m_irq, m_fiq});
      if ($urandom_range(3) == 0) src = src ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      if ($urandom_range(9) < 4) begin
        int k = $urandom_range(3, 11);
        bus_we = 1;
        bus_addr = {1'b0, 4'(k), ($urandom_range(1) == 1), 2'b00};
        bus_wdata = ($urandom_range(7) == 0) ? 32'hFFFF_FFFF : $urandom;
      end else begin
        logic [7:0] a;
        bus_we = 0;
        a = {($urandom_range(15) == 0), 4'($urandom_range(12)), ($urandom_range(1) == 1), 2'b00};
        rd(a, rtag(a), m_read(a));
      end
    end
    @(negedge clk); bus_we = 0;
    finish_run();
  end
endmodule